// File: doc/BRIEF.md
# Block Copy and Byte Search Sequencer

This block is a small sequential engine that walks memory one byte per iteration. A single start pulse loads a source pointer, a destination pointer, a byte count, an 8-bit key and the current flag byte. It also selects the operation (copy or search), the direction (pointers step up or down) and the mode (one iteration only, or repeat until the termination condition). The engine then drives a synchronous memory port until the sequence ends. It raises a one-cycle done pulse and shows the updated pointers, count and flag byte on its outputs.

A copy iteration reads the byte at the source pointer and writes it to the destination pointer. A search iteration reads the byte at the source pointer and compares it with the key; it never writes. The count is decremented before it is tested, so a starting count of zero behaves as 65536. In repeat mode a copy runs until the count reaches zero. A search runs until the byte equals the key or the count reaches zero, whichever comes first. The memory port has a read latency of one cycle: data for a read issued in one cycle is on `mem_rdata` in the next cycle.

Top module: `blkxfer_seq`

## Requirements
- R1: A copy iteration issues one read at the source pointer and then one write of that byte at the destination pointer. The read and the write never occur in the same cycle. Both pointers then move by one (up when `dir_down`=0, down when `dir_down`=1), and the count drops by one.
- R2: A search iteration reads at the source pointer and moves only that pointer by one in the selected direction. The count drops by one, the destination pointer stays unchanged, and no write is issued.
- R3: With `repeat_en`=1 a copy keeps iterating until the count reaches zero. With `repeat_en`=0 either operation performs exactly one iteration.
- R4: With `repeat_en`=1 a search stops after the first iteration whose byte equals the key, or after the iteration that brings the count to zero, whichever happens first.
- R5: Flag byte layout: bit 7 sign, bit 6 zero, bit 4 half-borrow, bit 2 parity/overflow, bit 1 subtract, bit 0 carry. Bits 5 and 3 keep the value loaded from `flags_in`. After a copy iteration, bits 4 and 1 are 0 and bits 7, 6 and 0 keep their loaded values.
- R6: After a search iteration, bit 1 is 1 and bit 0 keeps its loaded value. The bench computes d = key - byte modulo 256. Bit 7 is bit 7 of d. Bit 6 is 1 when key equals byte. Bit 4 is 1 when the low nibble of key is below the low nibble of byte.
- R7: After every iteration, bit 2 is 1 when the new count is non-zero and 0 when it is zero. The count is decremented before the test, so a starting count of 0 becomes 0xFFFF after the first iteration and does not stop a repeat sequence.
- R8: Each iteration takes exactly two cycles (read, then write or compare). `done` is high for exactly one cycle, 2N cycles after the clock edge that accepted `start`, where N is the number of iterations. `busy` is high from the accepting edge until after the done cycle. After reset `busy`, `done`, `mem_rd` and `mem_we` are 0.
- R9: Pointers wrap modulo 65536 in both directions.
- R10: A `start` pulse that arrives while `busy` is high is ignored. The running sequence finishes with the operands it was started with.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse, accepted only while idle |
| op_search | input | 1 | 1 = search, 0 = copy |
| dir_down | input | 1 | 1 = pointers step down, 0 = step up |
| repeat_en | input | 1 | 1 = repeat until termination, 0 = single iteration |
| src_in | input | 16 | Initial source pointer |
| dst_in | input | 16 | Initial destination pointer |
| cnt_in | input | 16 | Initial count |
| key_in | input | 8 | Search key |
| flags_in | input | 8 | Flag byte before the sequence |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |
| src_out | output | 16 | Current source pointer |
| dst_out | output | 16 | Current destination pointer |
| cnt_out | output | 16 | Current count |
| flags_out | output | 8 | Current flag byte |
| mem_addr | output | 16 | Memory address |
| mem_rd | output | 1 | Memory read strobe |
| mem_we | output | 1 | Memory write strobe |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, one cycle after `mem_rd` |

## Verification
The bench timestamps the clock edge that accepts each start. It expects the done pulse exactly 2N cycles after that edge, with pointers, count and flags already final in that same cycle. A driver computes N and the final values from its own byte-level model and pushes them into a queue. A monitor samples on the falling edge and compares the popped item with the outputs in the cycle in which `done` is seen; a pulse that arrives one cycle early or late pairs with wrong register values or with an empty queue. Memory contents after each copy are compared once the done cycle has passed, when the last write has landed.

// File: rtl/blkxfer_pkg.sv
package blkxfer_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_EX   = 2'd2,
    ST_FIN  = 2'd3
  } seq_state_t;

  localparam int FLAG_W  = 8;
  localparam int FB_SIGN = 7;
  localparam int FB_ZERO = 6;
  localparam int FB_HALF = 4;
  localparam int FB_PV   = 2;
  localparam int FB_SUB  = 1;
  localparam int FB_CY   = 0;
endpackage

// File: rtl/blkxfer_ctrl.sv
module blkxfer_ctrl
  import blkxfer_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic srch_in,
  input  logic rpt_in,
  input  logic cnt_last,
  input  logic match,
  output logic load,
  output logic rd_en,
  output logic step,
  output logic done,
  output logic busy,
  output logic srch_q,
  output logic rpt_q
);
  seq_state_t state_q, state_d;
  logic       stop;

  assign load  = (state_q == ST_IDLE) && start;
  assign rd_en = (state_q == ST_RD);
  assign step  = (state_q == ST_EX);
  assign done  = (state_q == ST_FIN);
  assign busy  = (state_q != ST_IDLE);
  assign stop  = !rpt_q || cnt_last || (srch_q && match);

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (start) state_d = ST_RD;
      ST_RD:   state_d = ST_EX;
      ST_EX:   state_d = stop ? ST_FIN : ST_RD;
      ST_FIN:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      srch_q  <= 1'b0;
      rpt_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (load) begin
        srch_q <= srch_in;
        rpt_q  <= rpt_in;
      end
    end
  end

  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r8_done_then_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
  a_r10_mode_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(srch_q) && $stable(rpt_q)));
  a_r3_single_iteration: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !rpt_q) |=> done);
endmodule

// File: rtl/blkxfer_regs.sv
module blkxfer_regs #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          step,
  input  logic          down_in,
  input  logic          srch,
  input  logic [AW-1:0] src_in,
  input  logic [AW-1:0] dst_in,
  input  logic [AW-1:0] cnt_in,
  output logic [AW-1:0] src_q,
  output logic [AW-1:0] dst_q,
  output logic [AW-1:0] cnt_q,
  output logic          cnt_last
);
  localparam int NPTR = 2;
  localparam logic [AW-1:0] ONE = AW'(1);

  logic          down_q;
  logic [AW-1:0] cnt_d;
  logic [AW-1:0] ptr_init [NPTR];
  logic [AW-1:0] ptr_q    [NPTR];
  logic          ptr_en   [NPTR];

  assign ptr_init[0] = src_in;
  assign ptr_init[1] = dst_in;
  assign ptr_en[0]   = step;
  assign ptr_en[1]   = step && !srch;
  assign src_q       = ptr_q[0];
  assign dst_q       = ptr_q[1];

  for (genvar g = 0; g < NPTR; g++) begin : g_ptr
    logic [AW-1:0] nxt;
    always_comb begin
      nxt = ptr_q[g];
      if (load)             nxt = ptr_init[g];
      else if (ptr_en[g])   nxt = down_q ? (ptr_q[g] - ONE) : (ptr_q[g] + ONE);
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ptr_q[g] <= '0;
      else        ptr_q[g] <= nxt;
    end

    a_r9_ptr_wraps: assert property (@(posedge clk) disable iff (!rst_n)
      ptr_en[g] |=> (ptr_q[g] == ($past(down_q) ? $past(ptr_q[g]) - ONE
                                                : $past(ptr_q[g]) + ONE)));
  end

  assign cnt_last = ((cnt_q - ONE) == '0);

  always_comb begin
    cnt_d = cnt_q;
    if (load)      cnt_d = cnt_in;
    else if (step) cnt_d = cnt_q - ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      down_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      if (load) down_q <= down_in;
    end
  end

  a_r1_count_drops: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (cnt_q == $past(cnt_q) - ONE));
  a_r2_dst_held: assert property (@(posedge clk) disable iff (!rst_n)
    (step && srch) |=> $stable(dst_q));
endmodule

// File: rtl/blkxfer_flags.sv
module blkxfer_flags
  import blkxfer_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  input  logic              srch,
  input  logic              cnt_last,
  input  logic [FLAG_W-1:0] flags_in,
  input  logic [DW-1:0]     key_in,
  input  logic [DW-1:0]     rdata,
  output logic [FLAG_W-1:0] flags_q,
  output logic              match
);
  localparam int HALF = DW / 2;

  logic [DW-1:0]     key_q;
  logic [DW-1:0]     diff;
  logic              half_borrow;
  logic [FLAG_W-1:0] step_flags;
  logic [FLAG_W-1:0] flags_d;

  assign diff        = key_q - rdata;
  assign half_borrow = key_q[HALF-1:0] < rdata[HALF-1:0];
  assign match       = (key_q == rdata);

  always_comb begin
    step_flags        = flags_q;
    step_flags[FB_PV] = !cnt_last;
    if (srch) begin
      step_flags[FB_SIGN] = diff[DW-1];
      step_flags[FB_ZERO] = (diff == '0);
      step_flags[FB_HALF] = half_borrow;
      step_flags[FB_SUB]  = 1'b1;
    end else begin
      step_flags[FB_HALF] = 1'b0;
      step_flags[FB_SUB]  = 1'b0;
    end
  end

  always_comb begin
    flags_d = flags_q;
    if (load)      flags_d = flags_in;
    else if (step) flags_d = step_flags;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      key_q   <= '0;
    end else begin
      flags_q <= flags_d;
      if (load) key_q <= key_in;
    end
  end

  a_r6_carry_kept: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (flags_q[FB_CY] == $past(flags_q[FB_CY])));
  a_r6_search_sub_set: assert property (@(posedge clk) disable iff (!rst_n)
    (step && srch) |=> flags_q[FB_SUB]);
  a_r5_copy_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !srch) |=> (!flags_q[FB_HALF] && !flags_q[FB_SUB]));
  a_r5_copy_sz_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !srch) |=> $stable(flags_q[FB_SIGN:FB_ZERO]));
  a_r7_pv_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (flags_q[FB_PV] == !$past(cnt_last)));
endmodule

// File: rtl/blkxfer_seq.sv
module blkxfer_seq
  import blkxfer_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              op_search,
  input  logic              dir_down,
  input  logic              repeat_en,
  input  logic [AW-1:0]     src_in,
  input  logic [AW-1:0]     dst_in,
  input  logic [AW-1:0]     cnt_in,
  input  logic [DW-1:0]     key_in,
  input  logic [FLAG_W-1:0] flags_in,
  output logic              busy,
  output logic              done,
  output logic [AW-1:0]     src_out,
  output logic [AW-1:0]     dst_out,
  output logic [AW-1:0]     cnt_out,
  output logic [FLAG_W-1:0] flags_out,
  output logic [AW-1:0]     mem_addr,
  output logic              mem_rd,
  output logic              mem_we,
  output logic [DW-1:0]     mem_wdata,
  input  logic [DW-1:0]     mem_rdata
);
  logic load, rd_en, step, srch_q, rpt_q, cnt_last, match;

  blkxfer_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .srch_in  (op_search),
    .rpt_in   (repeat_en),
    .cnt_last (cnt_last),
    .match    (match),
    .load     (load),
    .rd_en    (rd_en),
    .step     (step),
    .done     (done),
    .busy     (busy),
    .srch_q   (srch_q),
    .rpt_q    (rpt_q)
  );

  blkxfer_regs #(.AW(AW)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .step     (step),
    .down_in  (dir_down),
    .srch     (srch_q),
    .src_in   (src_in),
    .dst_in   (dst_in),
    .cnt_in   (cnt_in),
    .src_q    (src_out),
    .dst_q    (dst_out),
    .cnt_q    (cnt_out),
    .cnt_last (cnt_last)
  );

  blkxfer_flags #(.DW(DW)) u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .step     (step),
    .srch     (srch_q),
    .cnt_last (cnt_last),
    .flags_in (flags_in),
    .key_in   (key_in),
    .rdata    (mem_rdata),
    .flags_q  (flags_out),
    .match    (match)
  );

  assign mem_rd    = rd_en;
  assign mem_we    = step && !srch_q;
  assign mem_addr  = rd_en ? src_out : dst_out;
  assign mem_wdata = mem_rdata;

  a_r1_rd_we_apart: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_we));
  a_r1_write_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && !srch_q) |=> mem_we);
  a_r2_search_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    srch_q |-> !mem_we);
  a_r3_copy_ends_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (done && rpt_q && !srch_q) |-> (cnt_out == '0));
endmodule

// File: tb/blkxfer_seq_tb.sv
module blkxfer_seq_tb;
  localparam int AW = 16;
  localparam int DW = 8;

  typedef struct {
    string       tag;
    logic [15:0] src;
    logic [15:0] dst;
    logic [15:0] cnt;
    logic [7:0]  flags;
    int          lat;
  } exp_t;

  logic        clk, rst_n, start, op_search, dir_down, repeat_en;
  logic [15:0] src_in, dst_in, cnt_in, src_out, dst_out, cnt_out, mem_addr;
  logic [7:0]  key_in, flags_in, flags_out, mem_wdata, mem_rdata;
  logic        busy, done, mem_rd, mem_we;

  logic [7:0] mem     [256];
  logic [7:0] ref_mem [256];
  exp_t       expq [$];
  int         n_cmp, n_bad, cyc, start_cyc;

  blkxfer_seq #(.AW(AW), .DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op_search(op_search),
    .dir_down(dir_down), .repeat_en(repeat_en), .src_in(src_in),
    .dst_in(dst_in), .cnt_in(cnt_in), .key_in(key_in), .flags_in(flags_in),
    .busy(busy), .done(done), .src_out(src_out), .dst_out(dst_out),
    .cnt_out(cnt_out), .flags_out(flags_out), .mem_addr(mem_addr),
    .mem_rd(mem_rd), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
    if (mem_rd) mem_rdata <= mem[mem_addr[7:0]];
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // monitor: pops one expected item per done pulse
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (expq.size() == 0) begin
        check("R8 unexpected done", 32'd1, 32'd0);
      end else begin
        exp_t e;
        e = expq.pop_front();
        check({e.tag, " src"},   32'(src_out),   32'(e.src));
        check({e.tag, " dst"},   32'(dst_out),   32'(e.dst));
        check({e.tag, " cnt"},   32'(cnt_out),   32'(e.cnt));
        check({e.tag, " flags"}, 32'(flags_out), 32'(e.flags));
        check("R8 done latency", 32'(cyc - start_cyc), 32'(e.lat));
      end
    end
  end

  always @(negedge clk) begin
    if (cyc > 150000) begin
      check("watchdog", 32'd1, 32'd0);
      finish_run();
    end
  end

  // reference model: computes final state, updates ref_mem for copies
  task automatic model(string tag, bit srch, bit down, bit rpt, logic [15:0] s,
                       logic [15:0] d, logic [15:0] c, logic [7:0] k,
                       logic [7:0] f);
    exp_t e;
    int   n = 0;
    bit   fin = 0;
    while (!fin) begin
      logic [7:0] b, df;
      b = ref_mem[s[7:0]];
      c = c - 16'd1;
      f[2] = (c != 0);
      if (srch) begin
        df = k - b;
        f[7] = df[7];
        f[6] = (k == b);
        f[4] = (k[3:0] < b[3:0]);
        f[1] = 1'b1;
      end else begin
        ref_mem[d[7:0]] = b;
        f[4] = 1'b0;
        f[1] = 1'b0;
        d = down ? d - 16'd1 : d + 16'd1;
      end
      s = down ? s - 16'd1 : s + 16'd1;
      n++;
      fin = !rpt || (c == 0) || (srch && k == b);
    end
    e.tag = tag; e.src = s; e.dst = d; e.cnt = c; e.flags = f; e.lat = 2 * n;
    expq.push_back(e);
  endtask

  task automatic run(string tag, bit srch, bit down, bit rpt, logic [15:0] s,
                     logic [15:0] d, logic [15:0] c, logic [7:0] k,
                     logic [7:0] f, bit poke = 0);
    model(tag, srch, down, rpt, s, d, c, k, f);
    @(negedge clk);
    op_search = srch; dir_down = down; repeat_en = rpt;
    src_in = s; dst_in = d; cnt_in = c; key_in = k; flags_in = f;
    start = 1'b1;
    start_cyc = cyc + 1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      // R10: second start with different operands while busy
      @(negedge clk);
      op_search = ~srch; dir_down = ~down; repeat_en = 1'b0;
      src_in = 16'h5555; dst_in = 16'h6666; cnt_in = 16'h0001;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (!done) @(negedge clk);
    @(negedge clk);
    check({tag, " R8 busy drop"}, 32'(busy), 32'd0);
    if (!srch) begin
      int bad = 0;
      for (int i = 0; i < 256; i++) if (mem[i] !== ref_mem[i]) bad++;
      check({tag, " R1 memory image"}, 32'(bad), 32'd0);
    end
  endtask

  initial begin
    n_cmp = 0; n_bad = 0; cyc = 0; start_cyc = 0;
    start = 0; op_search = 0; dir_down = 0; repeat_en = 0;
    src_in = 0; dst_in = 0; cnt_in = 0; key_in = 0; flags_in = 0;
    mem_rdata = 0;
    for (int i = 0; i < 256; i++) begin
      mem[i]     = 8'(i * 7 + 3);
      ref_mem[i] = 8'(i * 7 + 3);
    end
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R8 reset busy", 32'(busy), 32'd0);
    check("R8 reset done", 32'(done), 32'd0);
    check("R8 reset strobes", 32'({mem_rd, mem_we}), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    run("R1 R3 single copy up",        0, 0, 0, 16'h0010, 16'h0080, 16'd5, 8'h00, 8'hFF);
    run("R3 R5 repeat copy up",        0, 0, 1, 16'h0020, 16'h0090, 16'd4, 8'h00, 8'hC9);
    run("R1 R5 repeat copy down",      0, 1, 1, 16'h0035, 16'h00A5, 16'd3, 8'h00, 8'h28);
    run("R2 R6 single search",         1, 0, 0, 16'h0012, 16'h0077, 16'd9, 8'h10, 8'h01);
    run("R4 R6 search match",          1, 0, 1, 16'h0050, 16'h0033, 16'd8, ref_mem[8'h52], 8'h00);
    run("R4 R7 search exhaust",        1, 0, 1, 16'h0060, 16'h0033, 16'd3, ref_mem[8'hF0], 8'h29);
    run("R7 zero count search",        1, 0, 1, 16'h0040, 16'h0000, 16'd0, ref_mem[8'h42], 8'h00);
    run("R9 copy wrap up",             0, 0, 1, 16'hFFFE, 16'h00C0, 16'd4, 8'h00, 8'h41);
    run("R9 search wrap down",         1, 1, 1, 16'h0001, 16'h0000, 16'd3, 8'h77, 8'h80);
    run("R10 start while busy",        0, 0, 1, 16'h0070, 16'h00D0, 16'd5, 8'h00, 8'h00, 1);
    run("R6 search low key",           1, 1, 0, 16'h0081, 16'h0000, 16'd2, 8'h01, 8'h00);

    repeat (4) @(negedge clk);
    check("R8 queue drained", 32'(expq.size()), 32'd0);
    finish_run();
  end
endmodule